// File: doc/BRIEF.md
# Ternary cyclic convolution accumulator

This block computes `e = r*h + m mod q` over polynomials reduced modulo `X^N - 1`. Here `r` has ternary coefficients, `h` has `QW`-bit coefficients, and `m` is a message term. The block holds three internal coefficient stores for `r`, `h` and `m`/`e`. The stores are filled through a 64-bit write port and inspected through a registered 64-bit read port. The result `e` replaces `m` in place.

The block contains no multiplier. Each nonzero ternary coefficient adds or subtracts a cyclically indexed `h` coefficient. One pass over all `N` coefficients of `r` produces four adjacent result coefficients in four accumulators, which are then written back as one packed word. A packed `r` word is fetched only when the scan enters a new word. Because `q = 2^QW`, the accumulators are `QW` bits wide and wrap on their own.

The host loads `r`, `h` and `m` while the block is idle, pulses `start`, waits for the one-cycle `done` pulse and then reads `e` back.

Top module: `tern_conv_acc`

## Requirements
- R1: After reset, `busy` and `done` are low. While idle with `start` low, `busy` stays low.
- R2: Read-port data appears one clock after the address is presented.
  - Selector 0 addresses `r`. Each 64-bit word holds 32 two-bit codes, with coefficient `i` in word `i/32` at bits `[2*(i%32)+1 : 2*(i%32)]`.
  - Selector 1 addresses `h` and selector 2 addresses `m`/`e`. Each word holds four 16-bit fields, with coefficient `j` in word `j/4` at bits `[16*(j%4) +: QW]`.
  - A read of `r` or `m` returns the written word.
  - A read of `h` returns each field's low `QW` bits, with the upper field bits and fields past `N-1` read as zero.
- R3: After a run, coefficient `k` of `e` equals `m_k + sum_i r_i * h_((k-i) mod N)`, reduced modulo `2^QW`.
- R4: The two-bit `r` codes mean the following: `01` is +1 (add `h`), `10` is -1 (subtract `h`), and `00` and `11` are both 0 (skip).
- R5: `m` is taken as `QW`-bit two's complement, so a value of `2^QW - 1` acts as -1 in the sum.
- R6: Let the clock edge that samples `start` be edge 0. `done` rises after edge `ceil(N/4)*(N+2)` and is high for exactly one cycle. `busy` falls at the same edge.
- R7: While `busy` is high, `start` and write-port writes are ignored. The run's results and the stored `h` are unchanged by them.
- R8: In the last result word, fields for coefficient indices at or past `N` are written as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| wr_en | input | 1 | Write strobe (honoured while idle) |
| wr_sel | input | 2 | Store select: 0 r, 1 h, 2 m/e, 3 none |
| wr_addr | input | AW | Word address for writes |
| wr_data | input | 64 | Packed write word |
| rd_sel | input | 2 | Store select for reads, same coding as wr_sel |
| rd_addr | input | AW | Word address for reads |
| rd_data | output | 64 | Registered read word |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
Each run takes `N+2` cycles per group of four coefficients. With `N = 11` and three groups, `done` is due exactly 39 edges after the `start` edge. The bench counts falling edges from that edge and checks the count, then checks one cycle later that the pulse has cleared.

Read data is due one edge after the address is driven, so every read drives on a falling edge and samples on the next falling edge. The bench pushes expected coefficients into a queue before the run. After `done`, it reads the result words back and pops the queue in the order the fields come out.

// File: rtl/tern_conv_acc.sv
module tern_conv_acc #(
  parameter int N  = 1171,
  parameter int QW = 11,
  localparam int WORDS  = (N + 3) / 4,
  localparam int RWORDS = (N + 31) / 32,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic [63:0]   wr_data,
  input  logic [1:0]    rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [63:0]   rd_data,
  output logic          busy,
  output logic          done
);
  localparam int RAW = (RWORDS > 1) ? $clog2(RWORDS) : 1;
  localparam int IW  = $clog2(N);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_SCAN, S_WRITE} st_t;

  st_t st;
  logic [63:0]   rmem [0:(1<<RAW)-1];
  logic [QW-1:0] hc   [0:N-1];
  logic [63:0]   me   [0:WORDS-1];
  logic [63:0]   rbuf;
  logic [RAW-1:0] rw;
  logic [IW-1:0] i, j0;
  logic [AW-1:0] g;
  logic [QW-1:0] acc [4];
  logic [IW:0]   jsum [4];
  logic [IW-1:0] jl [4];
  logic [QW-1:0] hv [4];
  logic [3:0]    lane_ok;
  logic [1:0]    code;
  logic [4:0]    ipos;
  logic [63:0]   eword, hword;

  assign busy = (st != S_IDLE);
  assign ipos = 5'(i);
  assign code = rbuf[{ipos, 1'b0} +: 2];

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      jsum[l] = {1'b0, j0} + (IW+1)'(l);
      if (jsum[l] >= (IW+1)'(N)) jsum[l] = jsum[l] - (IW+1)'(N);
      jl[l] = jsum[l][IW-1:0];
      hv[l] = hc[jl[l]];
      lane_ok[l] = (4 * int'(g) + l) < N;
      eword[16*l +: 16] = lane_ok[l] ? {{(16-QW){1'b0}}, acc[l]} : 16'd0;
    end
  end

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      if ((4 * int'(rd_addr) + l) < N)
        hword[16*l +: 16] = {{(16-QW){1'b0}}, hc[IW'(4 * int'(rd_addr) + l)]};
      else
        hword[16*l +: 16] = 16'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_WRITE) begin
      me[g] <= eword;
    end else if (wr_en && st == S_IDLE) begin
      case (wr_sel)
        2'd0: if (int'(wr_addr) < RWORDS) rmem[RAW'(wr_addr)] <= wr_data;
        2'd1: for (int l = 0; l < 4; l++)
                if ((4 * int'(wr_addr) + l) < N)
                  hc[IW'(4 * int'(wr_addr) + l)] <= wr_data[16*l +: QW];
        2'd2: if (int'(wr_addr) < WORDS) me[wr_addr] <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        2'd0: rd_data <= (int'(rd_addr) < RWORDS) ? rmem[RAW'(rd_addr)] : 64'd0;
        2'd1: rd_data <= hword;
        2'd2: rd_data <= (int'(rd_addr) < WORDS) ? me[rd_addr] : 64'd0;
        default: rd_data <= 64'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      g    <= '0;
      i    <= '0;
      j0   <= '0;
      rw   <= '0;
      rbuf <= '0;
      done <= 1'b0;
      for (int l = 0; l < 4; l++) acc[l] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          g  <= '0;
          st <= S_INIT;
        end
        S_INIT: begin
          for (int l = 0; l < 4; l++) acc[l] <= me[g][16*l +: QW];
          rbuf <= rmem[0];
          rw   <= '0;
          i    <= '0;
          j0   <= IW'(4 * int'(g));
          st   <= S_SCAN;
        end
        S_SCAN: begin
          for (int l = 0; l < 4; l++) begin
            if (code == 2'b01)      acc[l] <= acc[l] + hv[l];
            else if (code == 2'b10) acc[l] <= acc[l] - hv[l];
          end
          j0 <= (j0 == '0) ? IW'(N - 1) : j0 - 1'b1;
          if (ipos == 5'd31) begin
            rw   <= rw + 1'b1;
            rbuf <= rmem[rw + 1'b1];
          end
          if (i == IW'(N - 1)) st <= S_WRITE;
          else                 i  <= i + 1'b1;
        end
        S_WRITE: begin
          if (int'(g) == WORDS - 1) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            g  <= g + 1'b1;
            st <= S_INIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tern_conv_acc_chk.sv
module tern_conv_acc_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done
);
  assert_stay_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind tern_conv_acc tern_conv_acc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
);

// File: tb/tb_tern_conv_acc.sv
`timescale 1ns/1ps
module tb_tern_conv_acc;
  localparam int N = 11;
  localparam int QW = 11;
  localparam int WORDS = (N + 3) / 4;
  localparam int AW = 2;
  localparam int RUN_CYC = WORDS * (N + 2);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic busy, done;

  int n_tests = 0, n_fail = 0;
  int rv [N];
  int hv [N];
  int mv [N];
  int exp_q [$];

  always #5 clk = ~clk;

  tern_conv_acc #(.N(N), .QW(QW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_sel(rd_sel), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .done(done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int addr, input logic [63:0] d);
    wr_sel = 2'(sel); wr_addr = AW'(addr); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int sel, input int addr, output logic [63:0] d);
    rd_sel = 2'(sel); rd_addr = AW'(addr);
    @(negedge clk);
    d = rd_data;
  endtask

  // driver: packs and loads stores, pushes expected coefficients
  task automatic load_case(input bit zero_as_11);
    logic [63:0] w;
    w = '0;
    for (int i = 0; i < N; i++) begin
      logic [1:0] c;
      c = (rv[i] == 1) ? 2'b01 : (rv[i] == -1) ? 2'b10 : (zero_as_11 ? 2'b11 : 2'b00);
      w[2*i +: 2] = c;
    end
    wr(0, 0, w);
    for (int a = 0; a < WORDS; a++) begin
      logic [63:0] hw, mw;
      hw = '0; mw = '0;
      for (int l = 0; l < 4; l++) begin
        if (4*a + l < N) begin
          hw[16*l +: 16] = 16'(hv[4*a+l]) | 16'hA800;
          mw[16*l +: 16] = 16'(mv[4*a+l] & 2047);
        end
      end
      wr(1, a, hw);
      wr(2, a, mw);
    end
    for (int k = 0; k < N; k++) begin
      int s;
      s = mv[k];
      for (int i = 0; i < N; i++) s += rv[i] * hv[(k - i + N) % N];
      exp_q.push_back(s & 2047);
    end
  endtask

  task automatic run(input string tag, input bit interfere);
    int c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 0;
    while (!done && c < 10*RUN_CYC) begin
      if (interfere && c == 5) begin
        start = 1'b1;
        wr_sel = 2'd1; wr_addr = '0; wr_data = 64'h0123_0456_0789_0654; wr_en = 1'b1;
      end
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
      c++;
    end
    check({tag, " R6 done latency"}, c, RUN_CYC);
    check({tag, " R6 busy low at done"}, busy, 0);
    @(negedge clk);
    check({tag, " R6 done one cycle"}, done, 0);
  endtask

  // monitor: reads results and pops the scoreboard
  task automatic monitor(input string tag);
    logic [63:0] d;
    for (int a = 0; a < WORDS; a++) begin
      rd(2, a, d);
      for (int l = 0; l < 4; l++) begin
        if (4*a + l < N) check({tag, " R3 coeff"}, d[16*l +: 16], exp_q.pop_front());
        else             check({tag, " R8 pad field"}, d[16*l +: 16], 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R6 actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 done after reset", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 still idle", busy, 0);

    // R2 readback
    wr(0, 0, 64'hDEAD_BEEF_1234_5678);
    rd(0, 0, d); check("R2 r readback", d, 64'hDEAD_BEEF_1234_5678);
    wr(2, 1, 64'h0FED_0CBA_0987_0654);
    rd(2, 1, d); check("R2 m readback", d, 64'h0FED_0CBA_0987_0654);
    wr(1, 2, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(1, 2, d); check("R2 h readback masked", d, 64'h0000_07FF_07FF_07FF);

    // R3: single +1 at r0, m zero -> e equals h
    for (int i = 0; i < N; i++) begin rv[i] = (i == 0); hv[i] = 100*i + 7; mv[i] = 0; end
    load_case(0); run("caseA", 0); monitor("caseA");

    // R4: -1 at r3, code 11 for zeros
    for (int i = 0; i < N; i++) begin rv[i] = (i == 3) ? -1 : 0; hv[i] = 2047 - 13*i; mv[i] = 5; end
    load_case(1); run("caseB R4", 0); monitor("caseB R4");

    // R3/R5: random r, h and ternary m including -1
    for (int i = 0; i < N; i++) begin
      rv[i] = int'($urandom % 3) - 1; hv[i] = int'($urandom % 2048); mv[i] = int'($urandom % 3) - 1;
    end
    mv[2] = -1;
    load_case(0); run("caseC R5", 0); monitor("caseC R5");

    // R4 mixed codes with random zeros as 11
    for (int i = 0; i < N; i++) begin
      rv[i] = int'($urandom % 3) - 1; hv[i] = int'($urandom % 2048); mv[i] = -1;
    end
    load_case(1); run("caseD R4", 0); monitor("caseD R4");

    // R7: start and h write during run are ignored
    for (int i = 0; i < N; i++) begin
      rv[i] = int'($urandom % 3) - 1; hv[i] = int'($urandom % 2048); mv[i] = int'($urandom % 3) - 1;
    end
    load_case(0); run("caseE R7", 1); monitor("caseE R7");
    rd(1, 0, d);
    check("R7 h unchanged", d, {5'd0, 11'(hv[3]), 5'd0, 11'(hv[2]), 5'd0, 11'(hv[1]), 5'd0, 11'(hv[0])});
    check("R7 idle after ignored start", busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule